// File: doc/BRIEF.md
# UART Receive Queue Interrupt Controller

This block sits beside the receive queue of a 16550-class serial port and decides when the processor should be interrupted about incoming data. It derives three signals from what the queue reports and from the port's configuration. The first is a level request, raised once the queue holds at least the selected number of characters. The second is an idle-timeout request, raised when characters wait in the queue while both the line and the processor have been quiet for a number of whole character times. The third is a ready flag showing that received data is present.

The queue storage, the deserializer and the interrupt identification encoding live elsewhere. The controller sees the queue only through its occupancy count and two strobes: one for a character being written into the queue, one for the processor removing a character. The timeout is measured in baud-clock ticks, so its wall-clock length follows the configured bit rate and frame size.

Top module: `rxq_irq_ctrl`

## Requirements
- R1: When either `fifo_en` or `rx_irq_en` is 0 at a clock edge, both `rda_irq` and `tmo_irq` are 0 after that edge, and the timeout timer is restarted.
- R2: With both enables at 1, `rda_irq` after a clock edge equals (`occ_cnt` >= selected level) as sampled at that edge. It rises one cycle after the count reaches the level and falls one cycle after the count drops below it.
- R3: `trig_sel` picks the level as follows: 0 selects 1, 1 selects FIFO_DEPTH/4, 2 selects FIFO_DEPTH/2, and 3 selects FIFO_DEPTH-2. With FIFO_DEPTH=16 these are 1, 4, 8 and 14.
- R4: With the queue non-empty, the enables at 1 and no strobe, `tmo_irq` rises on the edge that samples the (TMO_CHARS x TICKS_PER_BIT x `char_bits`)-th `baud_tick` counted from the most recent restart. The restarting edge itself counts no tick.
- R5: `char_bits` is the full frame length in bits, with start, parity and every stop bit included (a second stop bit adds one). A value of 0 is treated as 1.
- R6: Clock cycles without `baud_tick` do not advance the timeout timer.
- R7: While `tmo_irq` is 1, a `push_stb` neither clears nor restarts it. A `pop_stb` clears it one cycle later and restarts the timer.
- R8: While `tmo_irq` is 0, either strobe restarts the timer from zero.
- R9: While `occ_cnt` is 0, `tmo_irq` is 0 after each edge and the timer stays in restart.
- R10: `data_ready` is 1 after any edge that samples `push_stb`=1. It is cleared after an edge that samples `occ_cnt`=0 with no push. It does not depend on either enable.
- R11: After reset, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | Queue mode enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| occ_cnt | input | OCC_W | Characters currently held in the receive queue |
| trig_sel | input | 2 | Level select (R3 encoding) |
| push_stb | input | 1 | One-cycle pulse: a character was written into the queue |
| pop_stb | input | 1 | One-cycle pulse: the processor removed a character |
| baud_tick | input | 1 | Baud clock enable, TICKS_PER_BIT pulses per bit time |
| char_bits | input | LEN_W | Frame length in bits, stop bits included |
| rda_irq | output | 1 | Level-reached request |
| tmo_irq | output | 1 | Idle-timeout request |
| data_ready | output | 1 | Received data present |

## Verification
The bench builds the controller with FIFO_DEPTH=16, TMO_CHARS=4 and TICKS_PER_BIT reduced to 4. This brings a full timeout window down to between 112 and 192 ticks for frame lengths of 7 to 12 bits. Many timeouts, restarts and pending-state clears therefore fit into a short random run. The depth of 16 lets every level from R3 be reached, the deepest being 14. TMO_CHARS above one exercises the character counter variant instead of the single-stage one.

// File: rtl/rxq_irq_pkg.sv
package rxq_irq_pkg;

   localparam int SEL_W = 2;

   // level chosen by the 2-bit select, derived from the queue depth
   function automatic int unsigned level_of(input int unsigned depth, input int unsigned sel);
      case (sel)
         0:       return 1;
         1:       return depth / 4;
         2:       return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

   function automatic int unsigned max_frame_bits(input int unsigned len_w);
      return (1 << len_w) - 1;
   endfunction

endpackage

// File: rtl/rxq_level_req.sv
module rxq_level_req #(
   parameter int FIFO_DEPTH = 16,
   parameter int OCC_W      = 5,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           run_en,
   input  logic [OCC_W-1:0]               occ,
   input  logic [rxq_irq_pkg::SEL_W-1:0]  sel,
   output logic                           rda
);
   localparam int NLVL = 1 << rxq_irq_pkg::SEL_W;

   logic [OCC_W-1:0] lvl_tab [NLVL];
   logic [OCC_W-1:0] lvl;
   logic             reached;

   for (genvar gi = 0; gi < NLVL; gi++) begin : g_tab
      assign lvl_tab[gi] = OCC_W'(rxq_irq_pkg::level_of(FIFO_DEPTH, gi));
   end

   assign lvl     = lvl_tab[sel];
   assign reached = run_en && (occ >= lvl);

   if (REG_OUT) begin : g_reg
      logic rda_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rda_q <= 1'b0;
         else        rda_q <= reached;
      end
      assign rda = rda_q;

      // R2
      lvl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run_en && occ >= lvl) |=> rda);
      // R2
      lvl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (occ < lvl) |=> !rda);
      // R1
      lvl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run_en |=> !rda);
   end else begin : g_comb
      assign rda = reached;

      // R2
      lvl_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (occ < lvl) |-> !rda);
   end

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int TICKS_PER_BIT = 16,
   parameter int TMO_CHARS     = 4,
   parameter int LEN_W         = 4,
   parameter int OCC_W         = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [OCC_W-1:0] occ,
   input  logic             push,
   input  logic             pop,
   input  logic             baud_tick,
   input  logic [LEN_W-1:0] char_bits,
   output logic             tmo
);
   localparam int MAX_BITS = rxq_irq_pkg::max_frame_bits(LEN_W);
   localparam int TICK_W   = $clog2(TICKS_PER_BIT * MAX_BITS + 1);

   logic [LEN_W-1:0]  bits_eff;
   logic [TICK_W-1:0] tick_lim;
   logic [TICK_W-1:0] tick_q;
   logic              tmo_q;
   logic              held;
   logic              restart;
   logic              char_done;
   logic              fire;

   assign bits_eff  = (char_bits == '0) ? LEN_W'(1) : char_bits;
   assign tick_lim  = TICK_W'(TICKS_PER_BIT) * TICK_W'(bits_eff) - TICK_W'(1);
   assign held      = !run_en || (occ == '0);
   assign restart   = held || pop || (push && !tmo_q);
   assign char_done = baud_tick && !tmo_q && (tick_q == tick_lim);

   // ticks inside one character time
   always_ff @(posedge clk) begin
      if (!rst_n || restart)        tick_q <= '0;
      else if (baud_tick && !tmo_q) tick_q <= char_done ? '0 : tick_q + TICK_W'(1);
   end

   // whole character times
   if (TMO_CHARS == 1) begin : g_single
      assign fire = char_done;
   end else begin : g_multi
      localparam int CHR_W = $clog2(TMO_CHARS);
      localparam logic [CHR_W-1:0] LAST = CHR_W'(TMO_CHARS - 1);
      logic [CHR_W-1:0] chr_q;
      always_ff @(posedge clk) begin
         if (!rst_n || restart) chr_q <= '0;
         else if (char_done)    chr_q <= (chr_q == LAST) ? '0 : chr_q + CHR_W'(1);
      end
      assign fire = char_done && (chr_q == LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 tmo_q <= 1'b0;
      else if (held || pop)       tmo_q <= 1'b0;
      else if (!restart && fire)  tmo_q <= 1'b1;
   end

   assign tmo = tmo_q;

   // R7
   pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !tmo_q);
   // R7
   push_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_q && push && !pop && run_en && occ != '0) |=> tmo_q);
   // R9
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |=> !tmo_q);
   // R1
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !tmo_q);
   // R6
   rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_q) |-> $past(baud_tick));

endmodule

// File: rtl/rxq_ready_flag.sv
module rxq_ready_flag #(
   parameter int OCC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occ,
   input  logic             push,
   output logic             ready
);
   logic ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        ready_q <= 1'b0;
      else if (push)     ready_q <= 1'b1;
      else if (occ == '0) ready_q <= 1'b0;
   end

   assign ready = ready_q;

   // R10
   push_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> ready);
   // R10
   empty_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && occ == '0) |=> !ready);

endmodule

// File: rtl/rxq_irq_ctrl.sv
module rxq_irq_ctrl #(
   parameter int FIFO_DEPTH    = 16,
   parameter int TICKS_PER_BIT = 16,
   parameter int TMO_CHARS     = 4,
   parameter int LEN_W         = 4,
   parameter bit REG_RDA       = 1'b1,
   parameter int OCC_W         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fifo_en,
   input  logic                          rx_irq_en,
   input  logic [OCC_W-1:0]              occ_cnt,
   input  logic [rxq_irq_pkg::SEL_W-1:0] trig_sel,
   input  logic                          push_stb,
   input  logic                          pop_stb,
   input  logic                          baud_tick,
   input  logic [LEN_W-1:0]              char_bits,
   output logic                          rda_irq,
   output logic                          tmo_irq,
   output logic                          data_ready
);
   if (FIFO_DEPTH < 4)           begin : g_bad_depth $error("FIFO_DEPTH must be at least 4"); end
   if (OCC_W < $clog2(FIFO_DEPTH + 1)) begin : g_bad_occ $error("OCC_W too narrow for FIFO_DEPTH"); end
   if (TICKS_PER_BIT < 1)        begin : g_bad_tpb   $error("TICKS_PER_BIT must be positive"); end
   if (TMO_CHARS < 1)            begin : g_bad_tmo   $error("TMO_CHARS must be positive"); end
   if (LEN_W < 2 || LEN_W > 6)   begin : g_bad_len   $error("LEN_W out of range"); end

   logic run_en;
   assign run_en = fifo_en && rx_irq_en;

   rxq_level_req #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .OCC_W      (OCC_W),
      .REG_OUT    (REG_RDA)
   ) u_level (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_en (run_en),
      .occ    (occ_cnt),
      .sel    (trig_sel),
      .rda    (rda_irq)
   );

   rxq_idle_timer #(
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .TMO_CHARS     (TMO_CHARS),
      .LEN_W         (LEN_W),
      .OCC_W         (OCC_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .occ       (occ_cnt),
      .push      (push_stb),
      .pop       (pop_stb),
      .baud_tick (baud_tick),
      .char_bits (char_bits),
      .tmo       (tmo_irq)
   );

   rxq_ready_flag #(
      .OCC_W (OCC_W)
   ) u_ready (
      .clk   (clk),
      .rst_n (rst_n),
      .occ   (occ_cnt),
      .push  (push_stb),
      .ready (data_ready)
   );

   // R11
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!rda_irq && !tmo_irq && !data_ready));

endmodule

// File: tb/rxq_irq_ctrl_tb.sv
`timescale 1ns/1ps
module rxq_irq_ctrl_tb;
   localparam int DEPTH = 16;
   localparam int TPB   = 4;
   localparam int TMOC  = 4;
   localparam int LW    = 4;
   localparam int OW    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_en = 1'b0, rx_irq_en = 1'b0;
   logic [OW-1:0] occ = '0;
   logic [1:0] trig_sel = '0;
   logic push = 1'b0, pop = 1'b0, baud = 1'b0;
   logic [LW-1:0] char_bits = 4'd10;
   logic rda, tmo, dr;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rxq_irq_ctrl #(
      .FIFO_DEPTH(DEPTH), .TICKS_PER_BIT(TPB), .TMO_CHARS(TMOC), .LEN_W(LW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
      .occ_cnt(occ), .trig_sel(trig_sel), .push_stb(push), .pop_stb(pop),
      .baud_tick(baud), .char_bits(char_bits),
      .rda_irq(rda), .tmo_irq(tmo), .data_ready(dr)
   );

   // R3 level table for a depth of 16
   function automatic int exp_lvl(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic int window(input logic [LW-1:0] b);
      return TMOC * TPB * ((b == 0) ? 1 : int'(b));
   endfunction

   // expected-value model from the requirements
   logic m_rda = 0, m_tmo = 0, m_dr = 0;
   int   m_cnt = 0;
   always @(posedge clk) begin
      logic en, held;
      en   = fifo_en && rx_irq_en;
      held = !en || (occ == 0);
      if (!rst_n) begin
         m_rda <= 0; m_tmo <= 0; m_dr <= 0; m_cnt <= 0;
      end else begin
         m_rda <= en && (int'(occ) >= exp_lvl(trig_sel));
         m_dr  <= push || (m_dr && occ != 0);
         if (held || pop || (push && !m_tmo)) begin
            m_cnt <= 0;
            if (held || pop) m_tmo <= 0;
         end else if (!m_tmo && baud) begin
            if (m_cnt + 1 == window(char_bits)) begin
               m_tmo <= 1; m_cnt <= 0;
            end else m_cnt <= m_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic p, input logic q, input logic b);
      @(negedge clk);
      if (rst_n) begin
         chk(rda == m_rda, "R2 model rda", rda, m_rda);
         chk(tmo == m_tmo, "R4 model tmo", tmo, m_tmo);
         chk(dr == m_dr,   "R10 model dr", dr, m_dr);
      end
      occ  = occ + OW'(push) - OW'(pop);
      push = p && (occ < OW'(DEPTH));
      pop  = q && (occ > 0);
      baud = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0);
   endtask

   // push one character, then exactly lim ticks must raise the timeout
   task automatic probe(input int lim, input string tag);
      step(1, 0, 0);
      for (int i = 0; i < lim; i++) step(0, 0, 1);
      chk(tmo == 0, tag, tmo, 0);
      step(0, 0, 0);
      chk(tmo == 1, tag, tmo, 1);
   endtask

   task automatic drain();
      while (occ != 0 || push) step(0, 1, 0);
      idle(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      // R11
      chk(rda == 0 && tmo == 0 && dr == 0, "R11 reset outputs", {rda, tmo, dr}, 0);
      fifo_en = 1; rx_irq_en = 1; char_bits = 4'd10; trig_sel = 0;
      idle(1);

      // R4 exact window for a 10-bit frame
      probe(160, "R4 timeout window");
      // R7 push while pending keeps it; pop clears
      step(1, 0, 0); step(0, 0, 0);
      chk(tmo == 1, "R7 push keeps pending", tmo, 1);
      step(0, 1, 0); step(0, 0, 0);
      chk(tmo == 0, "R7 pop clears", tmo, 0);
      // R6 idle cycles without ticks do not count
      idle(400);
      chk(tmo == 0, "R6 no ticks no timeout", tmo, 0);
      for (int i = 0; i < 160; i++) step(0, 0, 1);
      step(0, 0, 0);
      chk(tmo == 1, "R6 ticks only", tmo, 1);
      step(0, 1, 0); idle(2);
      // R8 push restarts the running timer
      step(1, 0, 0);
      for (int i = 0; i < 100; i++) step(0, 0, 1);
      step(1, 0, 0);
      for (int i = 0; i < 159; i++) step(0, 0, 1);
      step(0, 0, 0);
      chk(tmo == 0, "R8 restart on push", tmo, 0);
      step(0, 0, 1); step(0, 0, 0);
      chk(tmo == 1, "R8 fires after restart", tmo, 1);
      drain();
      // R9 empty queue holds the timer
      for (int i = 0; i < 300; i++) step(0, 0, 1);
      chk(tmo == 0, "R9 empty no timeout", tmo, 0);
      chk(dr == 0, "R10 empty clears ready", dr, 0);
      // R5 twelve-bit frame (two stop bits) lengthens the window
      char_bits = 4'd12;
      probe(192, "R5 12-bit window");
      drain();
      char_bits = 4'd10;

      // R3 each level; R2 falling side while draining
      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s);
         for (int k = 1; k <= DEPTH; k++) begin
            step(1, 0, 0); idle(2);
            chk(rda == (k >= exp_lvl(2'(s))), "R3 level reach", rda, k >= exp_lvl(2'(s)));
         end
         for (int k = DEPTH - 1; k >= 0; k--) begin
            step(0, 1, 0); idle(2);
            chk(rda == (k >= exp_lvl(2'(s))), "R2 level fall", rda, k >= exp_lvl(2'(s)));
         end
      end

      // R1 enables gate both requests; R10 ready ignores them
      trig_sel = 2'd1;
      for (int i = 0; i < 6; i++) step(1, 0, 0);
      for (int i = 0; i < 170; i++) step(0, 0, 1);
      idle(1);
      chk(rda == 1 && tmo == 1, "R1 both requests up", {rda, tmo}, 3);
      fifo_en = 0; idle(2);
      chk(rda == 0 && tmo == 0, "R1 queue mode off", {rda, tmo}, 0);
      step(1, 0, 0); idle(1);
      chk(dr == 1, "R10 ready without enables", dr, 1);
      fifo_en = 1; rx_irq_en = 0; idle(2);
      chk(rda == 0 && tmo == 0, "R1 irq enable off", {rda, tmo}, 0);
      rx_irq_en = 1;
      drain();

      // constrained random mix against the model
      for (int seg = 0; seg < 40; seg++) begin
         bit quiet;
         quiet = ($urandom % 2) == 1;
         trig_sel = 2'($urandom % 4);
         fifo_en = ($urandom % 10) != 0;
         rx_irq_en = ($urandom % 10) != 0;
         for (int c = 0; c < 400; c++) begin
            logic p, q, b;
            if (occ == 0 && !push) char_bits = 4'(7 + $urandom % 6);
            p = quiet ? (($urandom % 300) == 0) : (($urandom % 6) == 0);
            q = quiet ? (($urandom % 300) == 0) : (($urandom % 7) == 0);
            b = ($urandom % 4) != 0;
            step(p, q, b);
         end
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule